// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, once per received frame, whether the frame is kept or dropped. Its decision rests only on the 48-bit destination address at the head of the frame. The address arrives one octet at a time, first octet first. The block sorts it into one of three classes: broadcast, multicast or unicast. It then applies the filter settings for that class. Broadcast frames are governed by their own enable. Multicast frames are kept only when their hash hits a 64-bit group table. Unicast frames are kept either when they equal the station address or when promiscuous unicast reception is enabled.

A receive enable gates the whole filter, and the filter only acts on it between frames. A frame that began while reception was on still gets its verdict after the enable is dropped. A frame that begins while reception is off is ignored. All settings, including the station address and the group table, are captured on the first octet of each frame, so register writes made mid-frame apply from the next frame onward.

Software normally brings the filter up with broadcast and multicast acceptance on and promiscuous unicast off. It writes the station address and the group table before it raises the receive enable.

A start octet that arrives while reception is off also abandons any frame still in progress.

Top module: `rx_dest_filter`

## Requirements
- R1: A destination of all 48 ones (broadcast) is accepted exactly when `acc_bcast` is 1.
- R2: For a multicast destination, the index is computed as follows. The register starts as 32'hFFFFFFFF. Each of the 6 octets is fed first to last, least significant bit first. For each bit, fb = reg[31] ^ bit, then reg is shifted left by one, and when fb is 1 it is XORed with 32'h04C11DB7. The index is reg[31:26] after the last bit. The frame is accepted exactly when `acc_mcast` is 1 and `hash_table[index]` is 1.
- R3: Broadcast frames are never judged by the multicast rule. Neither `acc_mcast`, `acc_allphys` nor the group table changes their verdict.
- R4: When `acc_allphys` is 1, every unicast destination is accepted. The setting has no effect on multicast frames.
- R5: When `acc_allphys` is 0, a unicast destination is accepted only if all 48 bits equal `station_addr`. The group table and `acc_mcast` play no part for unicast.
- R6: Octet k of the address occupies bits [8k+7:8k] of `station_addr`, and octet 0 is received first. Bit 0 of octet 0 set means group (multicast), unless all 48 bits are 1. Bit 0 clear means unicast.
- R7: `verdict_vld` is a single-cycle pulse. It is high in the cycle after the clock edge that captures the sixth address octet, and it occurs once per frame. `verdict_accept` is valid with it and is 0 otherwise. Octets after the sixth, and idle cycles between octets, do not change the verdict.
- R8: The settings in force at the first octet decide the frame, even if they change before the sixth octet.
- R9: A frame whose first octet arrives while `rx_on` is 0 yields no verdict. Clearing `rx_on` after a frame has started still lets that frame reach its verdict. Setting `rx_on` again resumes verdicts from the next frame.
- R10: After reset, `verdict_vld` and `verdict_accept` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | An address octet is present on `byte_data` |
| frm_first | input | 1 | Qualifies `byte_vld`: this octet is the first of a frame |
| byte_data | input | 8 | Received octet |
| rx_on | input | 1 | Receive enable, applied at frame starts |
| acc_bcast | input | 1 | Keep broadcast frames |
| acc_mcast | input | 1 | Keep multicast frames that hit the group table |
| acc_allphys | input | 1 | Keep every unicast frame |
| station_addr | input | 48 | Station unicast address, octet 0 in bits [7:0] |
| hash_table | input | 64 | Multicast group table, one bit per hash index |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | 1 = keep the frame, qualified by `verdict_vld` |

## Verification
Each address class is tried with several combinations of the three accept controls. For group addresses and for broadcast, the table is programmed either with only the address's own hash bit set or with every bit except that one set. This separates a real hash lookup from a rule that ignores the table. Addresses that differ from all ones or from the station address in a single octet check the class boundaries and the full-width compare. Further frames are sent with gaps between octets, with trailing octets, with settings changed mid-frame, and with the receive enable toggled around frame starts, to check the timing and gating rules.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   // Accept controls captured at frame start
   typedef struct packed {
      logic bcast_en;
      logic mcast_en;
      logic allphys_en;
   } rxf_mode_t;

   // One octet of CRC-32, bits consumed LSB first, MSB-first register form
   function automatic logic [31:0] crc_octet(input logic [31:0] c,
                                             input logic [7:0]  d,
                                             input logic [31:0] poly);
      logic [31:0] r;
      r = c;
      for (int b = 0; b < 8; b++) begin
         r = {r[30:0], 1'b0} ^ (((r[31] ^ d[b]) == 1'b1) ? poly : 32'h0);
      end
      return r;
   endfunction

endpackage

// File: rtl/rxf_addr_cap.sv
module rxf_addr_cap #(
   parameter int N_OCT = 6,
   parameter int POS_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [POS_W-1:0]   pos,
   input  logic [7:0]         data,
   output logic [8*N_OCT-1:0] addr_full
);

   for (genvar k = 0; k < N_OCT; k++) begin : g_oct
      logic [7:0] oct_q;
      logic       hit;

      assign hit = wr && (pos == POS_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   oct_q <= '0;
         else if (hit) oct_q <= data;
      end

      // Current octet bypasses its register so the last one is usable at once
      assign addr_full[8*k +: 8] = hit ? data : oct_q;
   end

endmodule

// File: rtl/rxf_hash.sv
module rxf_hash #(
   parameter int          HASH_BITS = 6,
   parameter logic [31:0] CRC_POLY  = 32'h04C11DB7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 restart,
   input  logic [7:0]           data,
   output logic [HASH_BITS-1:0] idx
);
   import rxf_pkg::*;

   logic [31:0] crc_q;
   logic [31:0] crc_nxt;

   assign crc_nxt = crc_octet(restart ? 32'hFFFF_FFFF : crc_q, data, CRC_POLY);
   assign idx     = crc_nxt[31 -: HASH_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= 32'hFFFF_FFFF;
      else if (wr)  crc_q <= crc_nxt;
   end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
   parameter int ADDR_W    = 48,
   parameter int HASH_BITS = 6,
   localparam int TBL_W    = 1 << HASH_BITS
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [ADDR_W-1:0]    station,
   input  logic [TBL_W-1:0]     table_bits,
   input  logic [HASH_BITS-1:0] idx,
   input  rxf_pkg::rxf_mode_t   mode,
   output logic                 accept
);

   logic is_bcast;
   logic is_group;

   assign is_bcast = &addr;
   assign is_group = addr[0];

   always_comb begin
      if (is_bcast)      accept = mode.bcast_en;
      else if (is_group) accept = mode.mcast_en & table_bits[idx];
      else               accept = mode.allphys_en | (addr == station);
   end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
   parameter int          ADDR_BYTES = 6,
   parameter int          HASH_BITS  = 6,
   parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
   localparam int         ADDR_W     = 8 * ADDR_BYTES,
   localparam int         TBL_W      = 1 << HASH_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic              frm_first,
   input  logic [7:0]        byte_data,
   input  logic              rx_on,
   input  logic              acc_bcast,
   input  logic              acc_mcast,
   input  logic              acc_allphys,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic [TBL_W-1:0]  hash_table,
   output logic              verdict_vld,
   output logic              verdict_accept
);
   import rxf_pkg::*;

   localparam int POS_W = $clog2(ADDR_BYTES + 1);

   if (ADDR_BYTES < 2) begin : g_bad_bytes
      $error("rx_dest_filter: ADDR_BYTES must be at least 2");
   end
   if (HASH_BITS < 1 || HASH_BITS > 12) begin : g_bad_hash
      $error("rx_dest_filter: HASH_BITS must be 1..12");
   end

   logic              busy_q;
   logic [POS_W-1:0]  cnt_q;
   rxf_mode_t         cfg_flags_q;
   logic [ADDR_W-1:0] station_q;
   logic [TBL_W-1:0]  table_q;

   logic             start;
   logic             abort;
   logic             take;
   logic             last;
   logic [POS_W-1:0] pos;

   assign start = byte_vld & frm_first & rx_on;
   assign abort = byte_vld & frm_first & ~rx_on;
   assign take  = start | (byte_vld & ~frm_first & busy_q);
   assign pos   = start ? '0 : cnt_q;
   assign last  = take & ~start & (cnt_q == POS_W'(ADDR_BYTES - 1));

   // Frame tracking: a frame opens on an enabled start octet and closes on its last address octet
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= POS_W'(1);
      end else if (abort || last) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         cnt_q  <= cnt_q + POS_W'(1);
      end
   end

   // Settings snapshot taken on the start octet
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_flags_q <= '{bcast_en: 1'b1, mcast_en: 1'b1, allphys_en: 1'b0};
         station_q   <= '0;
         table_q     <= '0;
      end else if (start) begin
         cfg_flags_q <= '{bcast_en: acc_bcast, mcast_en: acc_mcast, allphys_en: acc_allphys};
         station_q   <= station_addr;
         table_q     <= hash_table;
      end
   end

   // The start octet itself is judged with the live inputs, later ones with the snapshot
   rxf_mode_t         mode_use;
   logic [ADDR_W-1:0] station_use;
   logic [TBL_W-1:0]  table_use;

   assign mode_use    = start ? '{bcast_en: acc_bcast, mcast_en: acc_mcast, allphys_en: acc_allphys}
                              : cfg_flags_q;
   assign station_use = start ? station_addr : station_q;
   assign table_use   = start ? hash_table   : table_q;

   logic [ADDR_W-1:0]    addr_full;
   logic [HASH_BITS-1:0] idx;
   logic                 accept_now;

   rxf_addr_cap #(.N_OCT(ADDR_BYTES), .POS_W(POS_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (take),
      .pos       (pos),
      .data      (byte_data),
      .addr_full (addr_full)
   );

   rxf_hash #(.HASH_BITS(HASH_BITS), .CRC_POLY(CRC_POLY)) u_hash (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (take),
      .restart (start),
      .data    (byte_data),
      .idx     (idx)
   );

   rxf_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_decide (
      .addr       (addr_full),
      .station    (station_use),
      .table_bits (table_use),
      .idx        (idx),
      .mode       (mode_use),
      .accept     (accept_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_vld    <= 1'b0;
         verdict_accept <= 1'b0;
      end else begin
         verdict_vld    <= last;
         verdict_accept <= last & accept_now;
      end
   end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       byte_vld,
   input logic       frm_first,
   input logic       rx_on,
   input logic       busy,
   input logic [2:0] cfg_flags,
   input logic       verdict_vld,
   input logic       verdict_accept
);

   // R7: the strobe never lasts two cycles
   p_vld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |=> !verdict_vld);

   // R7: a verdict follows a cycle that carried an octet
   p_vld_after_octet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |-> $past(byte_vld));

   // R7: accept is qualified by the strobe
   p_accept_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict_vld |-> !verdict_accept);

   // R9: verdicts only come out of an open frame
   p_vld_needs_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |-> $past(busy));

   // R9: a start octet while disabled never opens a frame
   p_off_no_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && frm_first && !rx_on) |=> !busy);

   // R8: the snapshot only changes on an enabled start octet
   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld && frm_first && rx_on) |=> $stable(cfg_flags));

endmodule

bind rx_dest_filter rxf_checker u_rxf_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .byte_vld       (byte_vld),
   .frm_first      (frm_first),
   .rx_on          (rx_on),
   .busy           (busy_q),
   .cfg_flags      (cfg_flags_q),
   .verdict_vld    (verdict_vld),
   .verdict_accept (verdict_accept)
);

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic        frm_first = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic        rx_on = 1'b0;
   logic        acc_bcast = 1'b1;
   logic        acc_mcast = 1'b1;
   logic        acc_allphys = 1'b0;
   logic [47:0] station_addr = 48'h5544_3322_1100;
   logic [63:0] hash_table = '0;
   logic        verdict_vld;
   logic        verdict_accept;

   always #2 clk = ~clk;

   rx_dest_filter i_rx_dest_filter (
      .clk            (clk),
      .rst_n          (rst_n),
      .byte_vld       (byte_vld),
      .frm_first      (frm_first),
      .byte_data      (byte_data),
      .rx_on          (rx_on),
      .acc_bcast      (acc_bcast),
      .acc_mcast      (acc_mcast),
      .acc_allphys    (acc_allphys),
      .station_addr   (station_addr),
      .hash_table     (hash_table),
      .verdict_vld    (verdict_vld),
      .verdict_accept (verdict_accept)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int n_vld  = 0;
   logic last_acc = 1'b0;

   always @(negedge clk) begin
      if (verdict_vld) begin
         n_vld++;
         last_acc = verdict_accept;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Hash index as the requirement defines it
   function automatic int hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic        fb;
      for (int i = 0; i < 48; i++) begin
         fb = c[31] ^ a[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ 32'h04C11DB7;
      end
      return int'(c[31:26]);
   endfunction

   task automatic send(input logic [47:0] a, input int nb, input int gap);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk);
         byte_vld  = 1'b1;
         frm_first = (i == 0);
         byte_data = (i < 6) ? a[8*i +: 8] : 8'h5A;
         if (gap > 0) begin
            @(negedge clk);
            byte_vld  = 1'b0;
            frm_first = 1'b0;
            repeat (gap - 1) @(negedge clk);
         end
      end
      @(negedge clk);
      byte_vld  = 1'b0;
      frm_first = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   typedef struct packed {
      logic [47:0] a;
      logic        ab;
      logic        am;
      logic        ap;
      logic        tm;   // 0: only own hash bit set, 1: all but own bit set
      logic        ex;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      {48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1},  // R1
      {48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
      {48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
      {48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
      {48'hA0B0_C0D0_E001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
      {48'hA0B0_C0D0_E001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
      {48'hA0B0_C0D0_E001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
      {48'h7FFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
      {48'h7FFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      {48'h5544_3322_1100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5
      {48'h5644_3322_1100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
      {48'h5544_3322_1102, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
      {48'h5644_3322_1100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4},  // R4
      {48'hFFFF_FFFF_FFFE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
      {48'hFFFF_FFFF_FFFE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4}   // R4
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int base;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(verdict_vld == 1'b0 && verdict_accept == 1'b0, "R10", int'({verdict_vld, verdict_accept}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(verdict_vld == 1'b0 && verdict_accept == 1'b0, "R10", int'({verdict_vld, verdict_accept}), 0);

      // R9: disabled receiver ignores a frame
      base = n_vld;
      send(48'hFFFF_FFFF_FFFF, 6, 0);
      check(n_vld == base, "R9", n_vld - base, 0);
      rx_on = 1'b1;

      // Vector table: R1..R6
      for (int v = 0; v < NV; v++) begin
         acc_bcast   = VECS[v].ab;
         acc_mcast   = VECS[v].am;
         acc_allphys = VECS[v].ap;
         hash_table  = 64'd1 << hidx(VECS[v].a);
         if (VECS[v].tm) hash_table = ~hash_table;
         base = n_vld;
         send(VECS[v].a, 6, 0);
         check(n_vld == base + 1 && last_acc == VECS[v].ex,
               $sformatf("R%0d vec %0d", VECS[v].rq, v), int'(last_acc), int'(VECS[v].ex));
      end

      // R7: exact cycle of the strobe
      acc_bcast = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i == 5) check(verdict_vld == 1'b0, "R7 early", int'(verdict_vld), 0);
         byte_vld  = 1'b1;
         frm_first = (i == 0);
         byte_data = 8'hFF;
      end
      @(negedge clk);
      byte_vld = 1'b0;
      check(verdict_vld == 1'b1 && verdict_accept == 1'b1, "R7 on time",
            int'({verdict_vld, verdict_accept}), 3);
      @(negedge clk);
      check(verdict_vld == 1'b0, "R7 one cycle", int'(verdict_vld), 0);

      // R7: gaps between octets and trailing octets
      acc_allphys = 1'b0;
      base = n_vld;
      send(48'h5544_3322_1100, 9, 2);
      check(n_vld == base + 1 && last_acc == 1'b1, "R7 gapped", n_vld - base, 1);

      // R8: settings changed after the first octet do not apply
      acc_bcast = 1'b1;
      base = n_vld;
      fork
         send(48'hFFFF_FFFF_FFFF, 6, 0);
         begin
            repeat (2) @(negedge clk);
            acc_bcast = 1'b0;
         end
      join
      check(n_vld == base + 1 && last_acc == 1'b1, "R8 bcast", int'(last_acc), 1);
      acc_allphys = 1'b0;
      base = n_vld;
      fork
         send(48'h0102_0304_0506, 6, 0);
         begin
            repeat (3) @(negedge clk);
            acc_allphys = 1'b1;
         end
      join
      check(n_vld == base + 1 && last_acc == 1'b0, "R8 allphys", int'(last_acc), 0);

      // R9: disable mid-frame still completes, then frames are ignored, then resume
      acc_bcast = 1'b1;
      base = n_vld;
      fork
         send(48'hFFFF_FFFF_FFFF, 6, 0);
         begin
            repeat (3) @(negedge clk);
            rx_on = 1'b0;
         end
      join
      check(n_vld == base + 1 && last_acc == 1'b1, "R9 finish", n_vld - base, 1);
      base = n_vld;
      send(48'hFFFF_FFFF_FFFF, 6, 0);
      check(n_vld == base, "R9 off", n_vld - base, 0);
      rx_on = 1'b1;
      base = n_vld;
      send(48'hFFFF_FFFF_FFFF, 6, 0);
      check(n_vld == base + 1 && last_acc == 1'b1, "R9 resume", n_vld - base, 1);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule